// File: doc/BRIEF.md
# Peak-Stop Histogram Builder over External SRAM

This block accumulates a histogram of a signed sample stream in an external single-port synchronous SRAM that holds one counter per bin. A start pulse launches a run. The block first writes zero into every bin. It then accepts samples and turns each accepted sample into a bin address. For that bin it reads the counter, adds one and writes the result back. The run stops when a written-back counter reaches the peak target chosen by a 2-bit select. The block then streams every bin, in ascending address order, over a valid/ready output.

The bin address is the most significant `ADDR_W` bits of the sample with the top bit inverted. This makes the address offset binary, so a zero-mean input piles up around the middle bin. While an increment is in flight the block takes no new samples, so the binned data is a sparse subset of the stream.

The controller is one state machine with these states:
- `ST_IDLE`: waits for start.
- `ST_CLEAR`: zero sweep, one write per cycle.
- `ST_BIN`: accepts a sample and drives its read address.
- `ST_INC_CAP`: captures the read data plus one.
- `ST_INC_WR`: writes the new value back and compares it with the target.
- `ST_INC_RET`: a recovery cycle.
- `ST_RO_ADDR`: drives the readout address.
- `ST_RO_HOLD`: presents the bin and waits for ready.

Its transitions are:
- `ST_IDLE` goes to `ST_CLEAR` on start.
- `ST_CLEAR` goes to `ST_BIN` after the last bin.
- `ST_BIN` goes to `ST_INC_CAP` on a valid sample.
- `ST_INC_CAP` goes to `ST_INC_WR`.
- `ST_INC_WR` goes to `ST_RO_ADDR` on a hit, otherwise to `ST_INC_RET`.
- `ST_INC_RET` goes to `ST_BIN`.
- `ST_RO_ADDR` goes to `ST_RO_HOLD`.
- `ST_RO_HOLD` goes to `ST_RO_ADDR` on a transfer, or to `ST_IDLE` when the last bin is transferred.

Top module: `hist_sram_builder`

## Requirements
- R1: After reset, `idle_rdy` is 1, and `busy`, `data_avail`, `sram_we` and `out_valid` are 0.
- R2: A start pulse in idle first writes 0 to every bin, one per cycle, at addresses 0 up to 2^ADDR_W-1 in ascending order. Earlier bin contents never appear in the readout.
- R3: The bin address is `{~s[SAMPLE_W-1], s[SAMPLE_W-2 -: ADDR_W-1]}`, so a zero sample lands in bin 2^(ADDR_W-1).
- R4: An accepted sample increments its bin by exactly one using a read, capture and write-back sequence. A sample is accepted in `ST_BIN` and the next acceptance is four cycles later at the earliest. Samples presented in the three cycles between are dropped.
- R5: `tgt_sel` is sampled at start. The target is 2^TGT_LOG2 for 00, 2^(TGT_LOG2-1) for 01, 2^(TGT_LOG2-2) for 10 and 2^(TGT_LOG2-3) for 11. Counting stops in the cycle whose write-back value reaches the target, and no later sample is counted.
- R6: Readout presents every bin from 0 to 2^ADDR_W-1 in order with its count. It advances only on `out_valid && out_ready`, and the bin and count hold steady while stalled.
- R7: After bin 2^ADDR_W-1 is transferred, `data_avail` drops and `idle_rdy` returns the next cycle.
- R8: A start pulse during counting or readout is ignored. No clear begins, and the block stays in its current phase.
- R9: Exactly one of `idle_rdy`, `busy` and `data_avail` is high at any time. `busy` covers the clear and counting phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample valid |
| in_sample | input | SAMPLE_W | Signed two's-complement sample |
| start | input | 1 | Single-cycle run start |
| tgt_sel | input | 2 | Peak target select |
| sram_addr | output | ADDR_W | SRAM address |
| sram_wdata | output | CNT_W | SRAM write data |
| sram_rdata | input | CNT_W | SRAM read data, one cycle after address |
| sram_we | output | 1 | SRAM write enable |
| out_valid | output | 1 | Readout item valid |
| out_bin | output | ADDR_W | Bin index of readout item |
| out_count | output | CNT_W | Count of readout item |
| out_ready | input | 1 | Readout consumer ready |
| busy | output | 1 | Clearing or counting |
| idle_rdy | output | 1 | Idle, start accepted |
| data_avail | output | 1 | Readout in progress |

## Verification
The bench builds the block with 8-bit samples, 4-bit bin addresses, 8-bit counts and TGT_LOG2 = 3, so the targets are 8, 4, 2 and 1. With these values a whole run fits in a few hundred cycles. Every target select, the full clear sweep and the end of readout at bin 15 can then be reached, and each of the 16 bins is compared against a bench-side model. Stalled readout, dropped samples between increments, and start pulses during counting and readout are all exercised.

// File: rtl/hist_pkg.sv
package hist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_BIN,
        ST_INC_CAP,
        ST_INC_WR,
        ST_INC_RET,
        ST_RO_ADDR,
        ST_RO_HOLD
    } hist_state_t;

endpackage

// File: rtl/hist_bin_map.sv
module hist_bin_map #(
    parameter int SAMPLE_W = 24,
    parameter int ADDR_W   = 15
) (
    input  logic [SAMPLE_W-1:0] sample,
    output logic [ADDR_W-1:0]   bin
);
    localparam int DROP_W = SAMPLE_W - ADDR_W;

    // Offset-binary re-centring: flip the sign, keep the next bits.
    assign bin = {~sample[SAMPLE_W-1], sample[SAMPLE_W-2 -: ADDR_W-1]};

    generate
        if (DROP_W > 0) begin : g_trunc
            logic [DROP_W-1:0] unused_low;
            assign unused_low = sample[DROP_W-1:0];
        end
    endgenerate

    initial begin
        assert (SAMPLE_W >= ADDR_W && ADDR_W >= 2)
            else $error("hist_bin_map: width mismatch");
    end
endmodule

// File: rtl/hist_target_dec.sv
module hist_target_dec #(
    parameter int CNT_W    = 24,
    parameter int TGT_LOG2 = 14
) (
    input  logic [1:0]       sel,
    output logic [CNT_W-1:0] target
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [31:0] shift_amt;

    always_comb begin
        shift_amt = 32'(TGT_LOG2) - 32'(sel);
        target    = ONE << shift_amt;
    end

    initial begin
        assert (TGT_LOG2 >= 3 && TGT_LOG2 < CNT_W)
            else $error("hist_target_dec: target exponent out of range");
    end
endmodule

// File: rtl/hist_sweep_ctr.sv
module hist_sweep_ctr #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    output logic [ADDR_W-1:0] idx,
    output logic              last
);
    localparam logic [ADDR_W-1:0] IDX_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (restart) begin
            idx <= '0;
        end else if (step) begin
            idx <= idx + 1'b1;
        end
    end

    assign last = (idx == IDX_MAX);
endmodule

// File: rtl/hist_sram_builder.sv
module hist_sram_builder
    import hist_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int ADDR_W   = 15,
    parameter int CNT_W    = 24,
    parameter int TGT_LOG2 = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic                start,
    input  logic [1:0]          tgt_sel,
    output logic [ADDR_W-1:0]   sram_addr,
    output logic [CNT_W-1:0]    sram_wdata,
    input  logic [CNT_W-1:0]    sram_rdata,
    output logic                sram_we,
    output logic                out_valid,
    output logic [ADDR_W-1:0]   out_bin,
    output logic [CNT_W-1:0]    out_count,
    input  logic                out_ready,
    output logic                busy,
    output logic                idle_rdy,
    output logic                data_avail
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    hist_state_t       st_q, st_d;
    logic [ADDR_W-1:0] bin_now, bin_q;
    logic [CNT_W-1:0]  cnt_q, tgt_q, tgt_now;
    logic [ADDR_W-1:0] sw_idx;
    logic              sw_last, sw_restart, sw_step;
    logic              take, hit;

    hist_bin_map #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W)) i_map (
        .sample (in_sample),
        .bin    (bin_now)
    );

    hist_target_dec #(.CNT_W(CNT_W), .TGT_LOG2(TGT_LOG2)) i_tgt (
        .sel    (tgt_sel),
        .target (tgt_now)
    );

    hist_sweep_ctr #(.ADDR_W(ADDR_W)) i_sweep (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (sw_restart),
        .step    (sw_step),
        .idx     (sw_idx),
        .last    (sw_last)
    );

    assign take = (st_q == ST_BIN) && in_valid;
    assign hit  = (st_q == ST_INC_WR) && (cnt_q >= tgt_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q <= '0;
            cnt_q <= '0;
            tgt_q <= '0;
        end else begin
            if (st_q == ST_IDLE && start) tgt_q <= tgt_now;
            if (take)                     bin_q <= bin_now;
            if (st_q == ST_INC_CAP)       cnt_q <= sram_rdata + CNT_ONE;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (start) st_d = ST_CLEAR;
            ST_CLEAR:   if (sw_last) st_d = ST_BIN;
            ST_BIN:     if (in_valid) st_d = ST_INC_CAP;
            ST_INC_CAP: st_d = ST_INC_WR;
            ST_INC_WR:  st_d = hit ? ST_RO_ADDR : ST_INC_RET;
            ST_INC_RET: st_d = ST_BIN;
            ST_RO_ADDR: st_d = ST_RO_HOLD;
            ST_RO_HOLD: if (out_ready) st_d = sw_last ? ST_IDLE : ST_RO_ADDR;
            default:    st_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        sram_addr  = '0;
        sram_wdata = '0;
        sram_we    = 1'b0;
        out_valid  = 1'b0;
        busy       = 1'b0;
        idle_rdy   = 1'b0;
        data_avail = 1'b0;
        sw_restart = 1'b0;
        sw_step    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                idle_rdy   = 1'b1;
                sw_restart = start;
            end
            ST_CLEAR: begin
                busy      = 1'b1;
                sram_addr = sw_idx;
                sram_we   = 1'b1;
                sw_step   = 1'b1;
            end
            ST_BIN: begin
                busy      = 1'b1;
                sram_addr = bin_now;
            end
            ST_INC_CAP, ST_INC_RET: begin
                busy      = 1'b1;
                sram_addr = bin_q;
            end
            ST_INC_WR: begin
                busy       = 1'b1;
                sram_addr  = bin_q;
                sram_wdata = cnt_q;
                sram_we    = 1'b1;
                sw_restart = hit;
            end
            ST_RO_ADDR: begin
                data_avail = 1'b1;
                sram_addr  = sw_idx;
            end
            ST_RO_HOLD: begin
                data_avail = 1'b1;
                out_valid  = 1'b1;
                sram_addr  = sw_idx;
                sw_step    = out_ready;
            end
            default: ;
        endcase
    end

    assign out_bin   = sw_idx;
    assign out_count = sram_rdata;

    AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({idle_rdy, busy, data_avail}) == 1); // R9

    AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> busy); // R2

    AST_TAKE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take ##1 !take ##1 !take); // R4

    AST_HIT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_we && busy && sram_wdata >= tgt_q && st_q == ST_INC_WR) |=> data_avail); // R5

    AST_RO_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_bin) && $stable(out_count)); // R6

    AST_RO_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (data_avail && $past(data_avail) && out_bin != $past(out_bin))
            |-> out_bin == $past(out_bin) + 1'b1); // R6

    AST_START_IGN_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (data_avail && start) |=> !busy); // R8

    AST_START_IGN_BIN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BIN && start && !in_valid) |=> (st_q == ST_BIN && !sram_we)); // R8
endmodule

// File: tb/test_hist_sram_builder.sv
module test_hist_sram_builder;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 8;
    localparam int AW = 4;
    localparam int CW = 8;
    localparam int TL = 3;
    localparam int NB = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_sample = '0;
    logic          start = 1'b0;
    logic [1:0]    tgt_sel = 2'b00;
    logic [AW-1:0] sram_addr;
    logic [CW-1:0] sram_wdata;
    logic [CW-1:0] sram_rdata = '0;
    logic          sram_we;
    logic          out_valid;
    logic [AW-1:0] out_bin;
    logic [CW-1:0] out_count;
    logic          out_ready = 1'b1;
    logic          busy, idle_rdy, data_avail;

    int n_chk = 0;
    int n_fail = 0;
    int got = 0;
    int cyc = 0;
    bit stall_mode = 1'b0;
    int rdy_ctr = 0;
    bit preload = 1'b0;
    logic [CW-1:0] preload_base = '0;
    logic [AW+CW-1:0] exp_q[$];
    logic [CW-1:0] mem [NB];

    always #(CLK_PERIOD/2) clk = ~clk;

    hist_sram_builder #(.SAMPLE_W(SW), .ADDR_W(AW), .CNT_W(CW), .TGT_LOG2(TL)) i_hist_sram_builder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .start(start), .tgt_sel(tgt_sel), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata), .sram_we(sram_we),
        .out_valid(out_valid), .out_bin(out_bin), .out_count(out_count),
        .out_ready(out_ready), .busy(busy), .idle_rdy(idle_rdy), .data_avail(data_avail)
    );

    // Synchronous single-port SRAM model
    always @(posedge clk) begin
        if (preload) begin
            for (int i = 0; i < NB; i++) mem[i] <= preload_base + CW'(i);
        end else if (sram_we) begin
            mem[sram_addr] <= sram_wdata;
        end
        sram_rdata <= mem[sram_addr];
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Ready driver and scoreboard monitor (one process: ready first, then compare)
    always @(negedge clk) begin
        rdy_ctr++;
        out_ready = stall_mode ? ((rdy_ctr % 3) != 0) : 1'b1;
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected readout item", out_bin, -1);
            end else begin
                logic [AW+CW-1:0] it;
                it = exp_q.pop_front();
                chk(out_bin == it[AW+CW-1:CW], "R6 readout bin order", out_bin, it[AW+CW-1:CW]);
                chk(out_count == it[CW-1:0], "R2/R3/R4/R5 bin count", out_count, it[CW-1:0]);
            end
            got++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    function automatic logic [SW-1:0] smp(input int k, input int seed);
        if (k == 0) return '0;
        return SW'((k % 5) * 48 + seed * 13 + k);
    endfunction

    function automatic int bin_of(input logic [SW-1:0] s);
        return int'((s >> (SW - AW)) ^ (1 << (AW - 1)));
    endfunction

    task automatic run(input logic [1:0] sel, input int seed, input bit stall,
                       input bit poke_bin, input bit poke_ro);
        int m [NB];
        int target, hit_k, n, base;
        bit clr_ok;
        target = 1 << (TL - int'(sel));
        for (int b = 0; b < NB; b++) m[b] = 0;
        hit_k = -1;
        for (int k = 0; k < 400; k++) begin
            int b;
            b = bin_of(smp(k, seed));
            m[b]++;
            if (m[b] == target) begin
                hit_k = k;
                break;
            end
        end
        for (int b = 0; b < NB; b++) exp_q.push_back({AW'(b), CW'(m[b])});
        base = got;
        stall_mode = stall;

        @(negedge clk);
        preload_base = CW'(8'hA0 + seed);
        preload = 1'b1;
        @(negedge clk);
        preload = 1'b0;

        tgt_sel = sel;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        tgt_sel = ~sel;
        chk(busy && !idle_rdy, "R9 busy after start", busy, 1);

        n = 0;
        clr_ok = 1'b1;
        while (sram_we && n < NB + 4) begin
            if (sram_wdata != 0 || sram_addr != AW'(n)) clr_ok = 1'b0;
            n++;
            @(negedge clk);
        end
        chk(n == NB, "R2 clear sweep length", n, NB);
        chk(clr_ok, "R2 clear writes zero ascending", clr_ok, 1);

        if (poke_bin) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy && !sram_we, "R8 start during counting ignored", sram_we, 0);
            @(negedge clk);
            chk(busy && !sram_we, "R8 no clear after ignored start", sram_we, 0);
        end

        for (int k = 0; k <= hit_k + 2; k++) begin
            in_valid = 1'b1;
            in_sample = smp(k, seed);
            @(negedge clk);
            for (int j = 0; j < 3; j++) begin
                in_sample = smp(k, seed) ^ {1'b1, {(SW-1){1'b0}}};
                @(negedge clk);
            end
        end
        in_valid = 1'b0;

        if (poke_ro) begin
            while (!data_avail) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(data_avail && !busy, "R8 start during readout ignored", busy, 0);
        end

        while (got < base + NB) @(negedge clk);
        @(negedge clk);
        chk(!data_avail && idle_rdy, "R7 readout end returns idle", data_avail, 0);
        chk(exp_q.size() == 0, "R6 all bins read out", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(idle_rdy && !busy && !data_avail, "R1 reset status", idle_rdy, 1);
        chk(!sram_we && !out_valid, "R1 reset outputs", sram_we, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(idle_rdy, "R1 idle after reset release", idle_rdy, 1);

        run(2'b10, 1, 1'b0, 1'b1, 1'b0);
        run(2'b00, 2, 1'b1, 1'b0, 1'b1);
        run(2'b11, 3, 1'b0, 1'b0, 1'b0);
        run(2'b01, 4, 1'b1, 1'b1, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule